// File: doc/BRIEF.md
# Modulo Address Post-Increment Unit

This block works out the value an address register takes after a load or store that uses post-increment addressing. Each access adds the access size in bytes (1, 2 or 4) to the address. When the circular-buffer mode is on, an access that lands on the last slot of the buffer reloads the buffer's start address instead. The last slot is the buffer end address rounded down to the access size.

The unit holds the buffer start and buffer end values in two control registers. They are written through a small indexed write port. The mode bit is taken from the processor status word. The caller supplies the current address value together with a step strobe. The updated address appears on a registered output one clock edge after the strobe, just as a register write-back only becomes visible when the execution packet completes. An illegal size code leaves the registered address as it is and raises an error flag for one cycle.

Top module: `madr_postinc`

## Requirements
- R1: After synchronous active-low reset, `addr_o` is 0, `err_o` is 0, and both the buffer start and buffer end registers are 0.
- R2: With status bit 8 clear, a step with a legal size loads `addr_o` with `addr_i + size` modulo 2^16 at the next clock edge.
- R3: With status bit 8 set, a step with a legal size whose `addr_i` equals the buffer end value with its low log2(size) bits cleared loads `addr_o` with the buffer start value.
- R4: With status bit 8 set, a step with a legal size whose `addr_i` does not equal the aligned end value loads `addr_o` with `addr_i + size` modulo 2^16. This holds even when `addr_i` equals an unaligned end value.
- R5: Only status bit 8 selects the circular mode. The other fifteen status bits have no effect on `addr_o`.
- R6: A write with `creg_sel_i` = 10 sets the buffer start register, and a write with `creg_sel_i` = 11 sets the buffer end register. A write to any other index changes neither register.
- R7: A control register write and a step in the same cycle: the step uses the register value from before the write, and the new value takes effect from the next step on.
- R8: The legal size codes on `size_i` are 1, 2 and 4. A step with any other code leaves `addr_o` unchanged, and `err_o` is 1 in the following cycle only.
- R9: Without a step, `addr_o` holds its value and `err_o` is 0 in the following cycle.
- R10: With the mode off, a step from 0xFFFF, 0xFFFE or 0xFFFC wraps past zero (for example, 0xFFFF + 1 = 0x0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Strobe: register the post-incremented address |
| addr_i | input | 16 | Current address register value |
| size_i | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| status_i | input | 16 | Status word; bit 8 enables circular mode |
| creg_wr_i | input | 1 | Control register write enable |
| creg_sel_i | input | 4 | Control register index (10 start, 11 end) |
| creg_wdata_i | input | 16 | Control register write data |
| addr_o | output | 16 | Registered next address value |
| err_o | output | 1 | One-cycle flag for an illegal size code |

## Verification
The buffer start register can be rewritten in the same cycle that a step reads it for a wrap. The bench provokes this by pointing the address at the aligned end and issuing the start-register write together with the step. It then checks that the wrapped address equals the old start value, and that a second wrap, one cycle later, returns the new value. The illegal-size path also coincides with mode and wrap conditions in the sweeps. There the bench checks that the held address and the error pulse win over any wrap.

// File: rtl/madr_pkg.sv
// Package: shared sizes and indices for the modulo address post-increment unit.
// Assumes byte-granular addresses and power-of-two access sizes.
package madr_pkg;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned SIZE_W    = 3;
    localparam int unsigned SEL_W     = 4;
    localparam int unsigned MAX_SIZE  = 4;
    localparam int unsigned MODE_BIT  = 8;
    localparam int unsigned START_IDX = 10;
    localparam int unsigned END_IDX   = 11;

    typedef struct packed {
        logic                legal;
        logic                wrap;
        logic [ADDR_W-1:0]   next;
    } step_res_t;
endpackage

// File: rtl/madr_ctrl_regs.sv
// Buffer start/end control registers.
// Assumes one write per cycle; indices other than START_IDX/END_IDX are ignored.
// New values are visible to the datapath from the cycle after the write.
module madr_ctrl_regs #(
    parameter int unsigned AW        = 16,
    parameter int unsigned SW        = 4,
    parameter int unsigned START_IDX = 10,
    parameter int unsigned END_IDX   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [SW-1:0] sel_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] start_o,
    output logic [AW-1:0] end_o
);
    localparam logic [SW-1:0] SEL_START = SW'(START_IDX);
    localparam logic [SW-1:0] SEL_END   = SW'(END_IDX);

    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;

    // Update the selected register on a write; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (wr_i) begin
            if (sel_i == SEL_START) start_q <= wdata_i;
            if (sel_i == SEL_END)   end_q   <= wdata_i;
        end
    end

    assign start_o = start_q;
    assign end_o   = end_q;
endmodule

// File: rtl/madr_next_calc.sv
// Combinational next-address calculation.
// Assumes the size is a byte count. A size is legal when it is a nonzero power
// of two no larger than MAX_SIZE. The wrap compare uses end AND NOT(size-1).
module madr_next_calc #(
    parameter int unsigned AW       = 16,
    parameter int unsigned SZW      = 3,
    parameter int unsigned MAX_SIZE = 4
) (
    input  logic           mode_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [SZW-1:0] size_i,
    input  logic [AW-1:0]  start_i,
    input  logic [AW-1:0]  end_i,
    output madr_pkg::step_res_t res_o
);
    localparam int unsigned NSIZES = $clog2(MAX_SIZE) + 1;

    logic [AW-1:0]     size_ext;
    logic [AW-1:0]     end_aligned;
    logic [NSIZES-1:0] size_hit;

    assign size_ext = {{(AW-SZW){1'b0}}, size_i};

    // One compare per legal power-of-two size.
    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        assign size_hit[g] = (size_i == SZW'(1 << g));
    end

    // Align the end address down to the access size.
    assign end_aligned = end_i & ~(size_ext - AW'(1));

    // Form the legality, wrap decision and next value.
    always_comb begin
        res_o.legal = |size_hit;
        res_o.wrap  = mode_i && (addr_i == end_aligned);
        res_o.next  = res_o.wrap ? start_i : (addr_i + size_ext);
    end
endmodule

// File: rtl/madr_addr_reg.sv
// Address result register and illegal-size error flag.
// Assumes the step strobe is a single-cycle request per access.
module madr_addr_reg #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          legal_i,
    input  logic [AW-1:0] next_i,
    output logic [AW-1:0] addr_o,
    output logic          err_o
);
    // Capture the next address on a legal step; flag illegal steps for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            err_o  <= 1'b0;
        end else begin
            err_o <= step_i && !legal_i;
            if (step_i && legal_i) addr_o <= next_i;
        end
    end
endmodule

// File: rtl/madr_postinc.sv
// Top: post-increment address update with optional circular-buffer reload.
// Assumes the status word is stable around the step. The result is registered.
module madr_postinc #(
    parameter int unsigned AW        = madr_pkg::ADDR_W,
    parameter int unsigned SZW       = madr_pkg::SIZE_W,
    parameter int unsigned SW        = madr_pkg::SEL_W,
    parameter int unsigned MAX_SIZE  = madr_pkg::MAX_SIZE,
    parameter int unsigned MODE_BIT  = madr_pkg::MODE_BIT,
    parameter int unsigned START_IDX = madr_pkg::START_IDX,
    parameter int unsigned END_IDX   = madr_pkg::END_IDX
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [SZW-1:0] size_i,
    input  logic [15:0]    status_i,
    input  logic           creg_wr_i,
    input  logic [SW-1:0]  creg_sel_i,
    input  logic [AW-1:0]  creg_wdata_i,
    output logic [AW-1:0]  addr_o,
    output logic           err_o
);
    logic [AW-1:0]       buf_start;
    logic [AW-1:0]       buf_end;
    madr_pkg::step_res_t res;

    madr_ctrl_regs #(
        .AW(AW), .SW(SW), .START_IDX(START_IDX), .END_IDX(END_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(creg_wr_i), .sel_i(creg_sel_i),
        .wdata_i(creg_wdata_i), .start_o(buf_start), .end_o(buf_end)
    );

    madr_next_calc #(
        .AW(AW), .SZW(SZW), .MAX_SIZE(MAX_SIZE)
    ) u_calc (
        .mode_i(status_i[MODE_BIT]), .addr_i(addr_i), .size_i(size_i),
        .start_i(buf_start), .end_i(buf_end), .res_o(res)
    );

    madr_addr_reg #(
        .AW(AW)
    ) u_areg (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .legal_i(res.legal),
        .next_i(res.next), .addr_o(addr_o), .err_o(err_o)
    );
endmodule

// File: rtl/madr_postinc_chk.sv
// Checker: port-level timing properties of the post-increment unit.
module madr_postinc_chk #(
    parameter int unsigned AW       = 16,
    parameter int unsigned SZW      = 3,
    parameter int unsigned MODE_BIT = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           step_i,
    input logic [AW-1:0]  addr_i,
    input logic [SZW-1:0] size_i,
    input logic [15:0]    status_i,
    input logic [AW-1:0]  addr_o,
    input logic           err_o
);
    logic bad_size;
    assign bad_size = ($countones(size_i) != 1) || (size_i > SZW'(4));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0) && !err_o);

    assert_linear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !bad_size && !status_i[MODE_BIT])
        |=> addr_o == AW'($past(addr_i) + AW'($past(size_i))));

    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && bad_size) |=> (err_o && $stable(addr_o)));

    assert_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_i && bad_size) |=> !err_o);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(addr_o));
endmodule

bind madr_postinc madr_postinc_chk #(.AW(AW), .SZW(SZW), .MODE_BIT(MODE_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .addr_i(addr_i), .size_i(size_i),
    .status_i(status_i), .addr_o(addr_o), .err_o(err_o)
);

// File: tb/madr_postinc_tb.sv
`timescale 1ns/1ps
module madr_postinc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [2:0]  size_i = 3'd1;
    logic [15:0] status_i = '0;
    logic        creg_wr_i = 1'b0;
    logic [3:0]  creg_sel_i = '0;
    logic [15:0] creg_wdata_i = '0;
    logic [15:0] addr_o;
    logic        err_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] m_start = '0, m_end = '0, m_addr = '0;

    always #2 clk = ~clk;

    madr_postinc u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .addr_i(addr_i), .size_i(size_i),
        .status_i(status_i), .creg_wr_i(creg_wr_i), .creg_sel_i(creg_sel_i),
        .creg_wdata_i(creg_wdata_i), .addr_o(addr_o), .err_o(err_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [15:0] a, input logic [2:0] s,
                                          input logic md);
        logic [15:0] al;
        al = m_end & ~(16'(s) - 16'd1);
        if (md && a == al) return m_start;
        return a + 16'(s);
    endfunction

    // Write a control register and keep the bench model in step.
    task automatic wr(input logic [3:0] sel, input logic [15:0] d);
        @(negedge clk);
        creg_wr_i = 1'b1; creg_sel_i = sel; creg_wdata_i = d;
        @(negedge clk);
        creg_wr_i = 1'b0;
        if (sel == 4'd10) m_start = d;
        if (sel == 4'd11) m_end = d;
    endtask

    // One step, checked after the edge that captures it.
    task automatic step(input string req, input logic [15:0] a, input logic [2:0] s,
                        input logic [15:0] st);
        logic legal;
        legal = (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
        @(negedge clk);
        step_i = 1'b1; addr_i = a; size_i = s; status_i = st;
        @(negedge clk);
        step_i = 1'b0;
        if (legal) m_addr = model(a, s, st[8]);
        check(req, addr_o, m_addr);
        check(legal ? req : "R8", 16'(err_o), legal ? 16'd0 : 16'd1);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] ends [4];
        ends[0] = 16'h0010; ends[1] = 16'h0013; ends[2] = 16'h00FF; ends[3] = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state, and zero registers seen through a wrap at address 0
        check("R1", addr_o, 16'h0000);
        check("R1", 16'(err_o), 16'h0000);
        rst_n = 1'b1;
        step("R1", 16'h0000, 3'd2, 16'h0100);
        check("R1", addr_o, 16'h0000);

        // R6: ignored indices, then start/end programming
        wr(4'd9, 16'h1234); wr(4'd12, 16'h5678);
        step("R6", 16'h0000, 3'd1, 16'h0100);
        wr(4'd10, 16'h0100);
        wr(4'd11, 16'h0010);

        // R2/R3/R4/R8 sweep over ends, sizes, addresses and mode
        for (int e = 0; e < 4; e++) begin
            wr(4'd11, ends[e]);
            for (int s = 0; s < 8; s++)
                for (int d = -8; d <= 1; d++)
                    for (int md = 0; md < 2; md++)
                        step(md ? "R3/R4" : "R2", ends[e] + 16'(d), 3'(s),
                             md ? 16'h0100 : 16'h0000);
        end

        // R5: other status bits have no effect
        wr(4'd11, 16'h0040);
        for (int b = 0; b < 16; b++) begin
            step("R5", 16'h0040, 3'd4, 16'(1 << b));
            step("R5", 16'h0040, 3'd4, ~16'(1 << b) & 16'hFEFF);
        end

        // R10: linear wrap past zero
        step("R10", 16'hFFFF, 3'd1, 16'h0000);
        step("R10", 16'hFFFE, 3'd2, 16'h0000);
        step("R10", 16'hFFFC, 3'd4, 16'h0000);

        // R9: idle cycles hold the address and keep err low
        step("R8", 16'h0002, 3'd3, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9", addr_o, m_addr);
            check("R9", 16'(err_o), 16'h0000);
        end

        // R7: write start in the same cycle as a wrapping step
        wr(4'd10, 16'h0200); wr(4'd11, 16'h0300);
        @(negedge clk);
        step_i = 1'b1; addr_i = 16'h0300; size_i = 3'd1; status_i = 16'h0100;
        creg_wr_i = 1'b1; creg_sel_i = 4'd10; creg_wdata_i = 16'h0400;
        @(negedge clk);
        step_i = 1'b0; creg_wr_i = 1'b0;
        check("R7", addr_o, 16'h0200);
        m_start = 16'h0400; m_addr = 16'h0200;
        step("R7", 16'h0300, 3'd1, 16'h0100);
        check("R7", addr_o, 16'h0400);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule